// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a 16-bit processor bus and an on-chip flash array. It accepts command words written to even addresses in the user region. It decodes only the low byte of each word. It tracks whether a second bus cycle is still owed. Once a sequence is complete, it hands a request to a back-end program/erase engine with a one-cycle start pulse. It then waits for the engine's done pulse.

Between commands it remembers a read mode. In array mode, bus reads return the array word. In status mode, they return the 8-bit status byte in the low half of the word. The status byte carries four flags:

- ready: no engine operation is in flight.
- erase error.
- program error.
- the last lock-bit query result.

Erase-all requests carry a block mask that always leaves the protected block out.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After synchronous reset the block is in array mode, no engine start is issued, and the status byte is 80h (bit 7 ready = 1, bits 6, 5 and 4 = 0, bits 3..0 always 0).
- R2: A write whose low byte is FFh selects array mode; the high byte (bits 15..8) is ignored, and every later read returns `array_rdata` until another command is accepted.
- R3: A write whose low byte is 70h selects status mode; reads then return 8'h00 in bits 15..8 and the status byte in bits 7..0, whatever the read address.
- R4: Program is 40h followed by a write of the data word to the same address; the block then pulses `eng_start` for one cycle with `eng_op` = 1, `eng_addr` = that address and `eng_wdata` = the data word.
- R5: Block erase is 20h followed by D0h written to the block's top even address; `eng_op` = 2 and `eng_blk_mask` is one-hot at the block index, bits [11:8] of that address.
- R6: Erase-all is A7h followed by D0h; `eng_op` = 3 and `eng_blk_mask` has every bit set except bit 13, the protected block.
- R7: Lock-bit program (77h) and lock-status read (71h), each followed by D0h at the block's top address, start the engine with `eng_op` = 4 and 5. When a lock-status read completes, status bit 6 takes `eng_lock`.
- R8: A second cycle that is not D0h where D0h is required, or a program data write to a different address, starts no engine operation and sets status bits 5 and 4.
- R9: From the start pulse until `eng_done`, status bit 7 reads 0 and every bus write is ignored. On `eng_done`, bit 7 returns to 1 and reads are in status mode.
- R10: At completion with `eng_fail` = 1, an erase operation (op 2 or 3) sets bit 5 and a program operation (op 1 or 4) sets bit 4. Both bits stay set across later successful operations.
- R11: A write whose low byte is 50h clears status bits 5 and 4 and leaves the read mode unchanged.
- R12: A write to an odd address, or to an address whose block index (bits [11:8]) is 14 or more, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per word |
| bus_addr | input | 12 | Bus byte address |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Read data, array word or status byte |
| array_rdata | input | 16 | Array word at `bus_addr` |
| eng_start | output | 1 | One-cycle engine request |
| eng_op | output | 3 | Operation: 1 program, 2 block erase, 3 erase-all, 4 lock program, 5 lock read |
| eng_addr | output | 12 | Target address of the request |
| eng_wdata | output | 16 | Program data word |
| eng_blk_mask | output | 14 | Blocks affected by the request |
| eng_done | input | 1 | One-cycle completion from the engine |
| eng_fail | input | 1 | Completion outcome, valid with `eng_done` |
| eng_lock | input | 1 | Lock-bit query result, valid with `eng_done` |

## Verification
Two events can land in the same clock cycle: an engine completion that reports a failure, and a bus write of the clear-status command. The bench provokes this by driving `eng_done`, `eng_fail` and a 50h write in one cycle while a block erase is running. The write must be dropped because the block is still busy at that edge, so the next status read must show 0A0h rather than 80h.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] CODE_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] CODE_READ_STATUS = 8'h70;
    localparam logic [7:0] CODE_CLEAR_STAT  = 8'h50;
    localparam logic [7:0] CODE_PROGRAM     = 8'h40;
    localparam logic [7:0] CODE_BLK_ERASE   = 8'h20;
    localparam logic [7:0] CODE_ERASE_ALL   = 8'hA7;
    localparam logic [7:0] CODE_LOCK_PROG   = 8'h77;
    localparam logic [7:0] CODE_LOCK_READ   = 8'h71;
    localparam logic [7:0] CODE_CONFIRM     = 8'hD0;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_PROG      = 3'd1,
        OP_BLK_ERASE = 3'd2,
        OP_ERASE_ALL = 3'd3,
        OP_LOCK_PROG = 3'd4,
        OP_LOCK_READ = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SECOND,
        PH_BUSY
    } phase_e;

    typedef enum logic {
        RM_ARRAY,
        RM_STATUS
    } rmode_e;

    typedef struct packed {
        logic       ready;
        logic       lock_bit;
        logic       erase_err;
        logic       prog_err;
        logic [3:0] rsvd;
    } status_t;

    function automatic op_e two_cycle_op(input logic [7:0] code);
        case (code)
            CODE_PROGRAM:   return OP_PROG;
            CODE_BLK_ERASE: return OP_BLK_ERASE;
            CODE_ERASE_ALL: return OP_ERASE_ALL;
            CODE_LOCK_PROG: return OP_LOCK_PROG;
            CODE_LOCK_READ: return OP_LOCK_READ;
            default:        return OP_NONE;
        endcase
    endfunction

    function automatic logic op_is_erase(input op_e op);
        return (op == OP_BLK_ERASE) || (op == OP_ERASE_ALL);
    endfunction

    function automatic logic op_is_write(input op_e op);
        return (op == OP_PROG) || (op == OP_LOCK_PROG);
    endfunction

endpackage

// File: rtl/flash_addr_check.sv
module flash_addr_check #(
    parameter int ADDR_W    = 12,
    parameter int BLK_SHIFT = 8,
    parameter int NUM_BLK   = 14
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_user
);
    localparam int BLK_IDX_W = ADDR_W - BLK_SHIFT;

    logic [BLK_IDX_W:0] blk_ext;

    assign blk_ext = {1'b0, addr[ADDR_W-1:BLK_SHIFT]};
    assign in_user = !addr[0] && (blk_ext < (BLK_IDX_W+1)'(NUM_BLK));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              eng_done,
    output phase_e            phase,
    output rmode_e            rmode,
    output op_e               op,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [15:0]       data_q,
    output logic              start,
    output logic              clr_pulse,
    output logic              err_pulse,
    output logic              done_ev
);
    logic [7:0] code;

    assign code    = wr_data[7:0];
    assign done_ev = (phase == PH_BUSY) && eng_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            rmode     <= RM_ARRAY;
            op        <= OP_NONE;
            tgt_addr  <= '0;
            data_q    <= '0;
            start     <= 1'b0;
            clr_pulse <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            start     <= 1'b0;
            clr_pulse <= 1'b0;
            err_pulse <= 1'b0;
            case (phase)
                PH_IDLE: if (wr_ok) begin
                    if (code == CODE_READ_ARRAY) begin
                        rmode <= RM_ARRAY;
                    end else if (code == CODE_READ_STATUS) begin
                        rmode <= RM_STATUS;
                    end else if (code == CODE_CLEAR_STAT) begin
                        clr_pulse <= 1'b1;
                    end else if (two_cycle_op(code) != OP_NONE) begin
                        op       <= two_cycle_op(code);
                        tgt_addr <= wr_addr;
                        rmode    <= RM_STATUS;
                        phase    <= PH_SECOND;
                    end
                end
                PH_SECOND: if (wr_ok) begin
                    if (op == OP_PROG) begin
                        if (wr_addr == tgt_addr) begin
                            data_q <= wr_data;
                            start  <= 1'b1;
                            phase  <= PH_BUSY;
                        end else begin
                            err_pulse <= 1'b1;
                            phase     <= PH_IDLE;
                        end
                    end else if (code == CODE_CONFIRM) begin
                        tgt_addr <= wr_addr;
                        start    <= 1'b1;
                        phase    <= PH_BUSY;
                    end else begin
                        err_pulse <= 1'b1;
                        phase     <= PH_IDLE;
                    end
                end
                PH_BUSY: if (eng_done) begin
                    rmode <= RM_STATUS;
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_BUSY_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst)
        start |-> (phase == PH_BUSY)); // R9
    AST_DONE_TO_STATUS: assert property (@(posedge clk) disable iff (rst)
        done_ev |=> (phase == PH_IDLE) && (rmode == RM_STATUS)); // R9
    AST_ERR_NO_START: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> !start && (phase == PH_IDLE)); // R8
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
    import flash_cmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    busy,
    input  logic    clr,
    input  logic    seq_err,
    input  logic    done_ev,
    input  op_e     op,
    input  logic    eng_fail,
    input  logic    eng_lock,
    output status_t sr
);
    logic lock_q, erase_q, prog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q  <= 1'b0;
            erase_q <= 1'b0;
            prog_q  <= 1'b0;
        end else if (clr) begin
            erase_q <= 1'b0;
            prog_q  <= 1'b0;
        end else if (seq_err) begin
            erase_q <= 1'b1;
            prog_q  <= 1'b1;
        end else if (done_ev) begin
            if (eng_fail && op_is_erase(op)) erase_q <= 1'b1;
            if (eng_fail && op_is_write(op)) prog_q  <= 1'b1;
            if (op == OP_LOCK_READ)          lock_q  <= eng_lock;
        end
    end

    always_comb begin
        sr.ready     = !busy;
        sr.lock_bit  = lock_q;
        sr.erase_err = erase_q;
        sr.prog_err  = prog_q;
        sr.rsvd      = '0;
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clr |=> !sr.erase_err && !sr.prog_err); // R11
    AST_SEQ_ERR_BOTH: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> sr.erase_err && sr.prog_err); // R8
    AST_ERASE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sr.erase_err && !clr) |=> sr.erase_err); // R10
    AST_PROG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sr.prog_err && !clr) |=> sr.prog_err); // R10
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BLK_SHIFT = 8,
    parameter int NUM_BLK   = 14,
    parameter int PROT_BLK  = NUM_BLK - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    input  logic [15:0]        array_rdata,
    output logic               eng_start,
    output logic [2:0]         eng_op,
    output logic [ADDR_W-1:0]  eng_addr,
    output logic [15:0]        eng_wdata,
    output logic [NUM_BLK-1:0] eng_blk_mask,
    input  logic               eng_done,
    input  logic               eng_fail,
    input  logic               eng_lock
);
    localparam int BLK_IDX_W = ADDR_W - BLK_SHIFT;

    logic               in_user, wr_ok, clr_pulse, err_pulse, done_ev;
    phase_e             phase;
    rmode_e             rmode;
    op_e                op;
    logic [ADDR_W-1:0]  tgt_addr;
    logic [15:0]        data_q;
    status_t            sr;
    logic [BLK_IDX_W-1:0] tgt_blk;
    logic [NUM_BLK-1:0] all_mask, one_mask;

    flash_addr_check #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .NUM_BLK(NUM_BLK)) u_addr (
        .addr    (bus_addr),
        .in_user (in_user)
    );

    assign wr_ok = bus_wr && in_user;

    flash_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_ok     (wr_ok),
        .wr_addr   (bus_addr),
        .wr_data   (bus_wdata),
        .eng_done  (eng_done),
        .phase     (phase),
        .rmode     (rmode),
        .op        (op),
        .tgt_addr  (tgt_addr),
        .data_q    (data_q),
        .start     (eng_start),
        .clr_pulse (clr_pulse),
        .err_pulse (err_pulse),
        .done_ev   (done_ev)
    );

    flash_status_reg u_stat (
        .clk      (clk),
        .rst      (rst),
        .busy     (phase == PH_BUSY),
        .clr      (clr_pulse),
        .seq_err  (err_pulse),
        .done_ev  (done_ev),
        .op       (op),
        .eng_fail (eng_fail),
        .eng_lock (eng_lock),
        .sr       (sr)
    );

    assign tgt_blk = tgt_addr[ADDR_W-1:BLK_SHIFT];

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_mask
        assign all_mask[b] = (b != PROT_BLK);
        assign one_mask[b] = (tgt_blk == BLK_IDX_W'(b));
    end

    assign eng_blk_mask = (op == OP_ERASE_ALL) ? all_mask : one_mask;
    assign eng_op       = op;
    assign eng_addr     = tgt_addr;
    assign eng_wdata    = data_q;
    assign bus_rdata    = (rmode == RM_STATUS) ? {8'h00, sr} : array_rdata;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start); // R4
    AST_NOT_READY_AT_START: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !sr.ready); // R9
    AST_ALL_SKIPS_PROT: assert property (@(posedge clk) disable iff (rst)
        (eng_start && eng_op == 3'd3) |->
            !eng_blk_mask[PROT_BLK] && ($countones(eng_blk_mask) == NUM_BLK - 1)); // R6
    AST_SINGLE_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (eng_start && eng_op == 3'd2) |-> ($countones(eng_blk_mask) == 1)); // R5
    AST_BAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !in_user && phase == PH_IDLE) |=>
            (phase == PH_IDLE) && $stable(rmode)); // R12
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && phase == PH_BUSY && !eng_done) |=>
            (phase == PH_BUSY) && $stable(rmode)); // R9
endmodule

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/100ps
module test_flash_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata, array_rdata;
    logic        eng_start, eng_done = 1'b0, eng_fail = 1'b0, eng_lock = 1'b0;
    logic [2:0]  eng_op;
    logic [11:0] eng_addr;
    logic [15:0] eng_wdata;
    logic [13:0] eng_blk_mask;

    int n_run = 0, n_fail = 0, n_start = 0;
    bit finished = 0;
    logic [2:0]  cap_op;
    logic [11:0] cap_addr;
    logic [15:0] cap_data;
    logic [13:0] cap_mask;

    always #2.5 clk = ~clk;

    assign array_rdata = {4'hA, bus_addr};

    flash_cmd_ctrl i_flash_cmd_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .array_rdata(array_rdata),
        .eng_start(eng_start), .eng_op(eng_op), .eng_addr(eng_addr),
        .eng_wdata(eng_wdata), .eng_blk_mask(eng_blk_mask),
        .eng_done(eng_done), .eng_fail(eng_fail), .eng_lock(eng_lock)
    );

    always @(negedge clk) if (eng_start) begin
        n_start++;
        cap_op = eng_op; cap_addr = eng_addr; cap_data = eng_wdata; cap_mask = eng_blk_mask;
    end

    // kind 1 = write, 2 = read and compare; {kind, req, addr, value}
    localparam int VEC_N = 13;
    localparam logic [39:0] VEC [VEC_N] = '{
        {4'd2, 4'd1,  16'h0000, 16'hA000},  // R1 array mode after reset
        {4'd1, 4'd3,  16'h0000, 16'h0070},  // R3
        {4'd2, 4'd3,  16'h0234, 16'h0080},  // R3 status at any address
        {4'd1, 4'd2,  16'h0100, 16'h55FF},  // R2 high byte ignored
        {4'd2, 4'd2,  16'h0100, 16'hA100},  // R2
        {4'd2, 4'd2,  16'h02F0, 16'hA2F0},  // R2 persists
        {4'd1, 4'd12, 16'h0101, 16'h0070},  // R12 odd address
        {4'd2, 4'd12, 16'h0100, 16'hA100},  // R12
        {4'd1, 4'd12, 16'h0E00, 16'h0070},  // R12 block 14
        {4'd2, 4'd12, 16'h0E00, 16'hAE00},  // R12
        {4'd1, 4'd3,  16'h0000, 16'hAB70},  // R3 high byte ignored
        {4'd2, 4'd3,  16'h0000, 16'h0080},  // R3
        {4'd1, 4'd2,  16'h0000, 16'h00FF}   // R2 back to array
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [15:0] exp);
        @(negedge clk); bus_addr = a; #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic finish_op(input logic fail, input logic lock);
        @(negedge clk); eng_done = 1'b1; eng_fail = fail; eng_lock = lock;
        @(negedge clk); eng_done = 1'b0; eng_fail = 1'b0; eng_lock = 1'b0;
    endtask

    task automatic chk_start(input string req, input int cnt, input logic [2:0] op,
                             input logic [13:0] mask);
        @(negedge clk); #1;
        chk({req, " start count"}, 16'(n_start), 16'(cnt));
        chk({req, " op"}, {13'd0, cap_op}, {13'd0, op});
        chk({req, " mask"}, {2'd0, cap_mask}, {2'd0, mask});
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 no start", {15'd0, eng_start}, 16'd0);
        for (int i = 0; i < VEC_N; i++) begin
            if (VEC[i][39:36] == 4'd1) wr(VEC[i][27:16], VEC[i][15:0]);
            else rd($sformatf("R%0d", VEC[i][35:32]), VEC[i][27:16], VEC[i][15:0]);
        end
        // R4 program, R9 busy behaviour
        wr(12'h100, 16'h0040); wr(12'h100, 16'h1234);
        chk_start("R4", 1, 3'd1, 14'h0002);
        chk("R4 addr", {4'd0, cap_addr}, 16'h0100);
        chk("R4 data", cap_data, 16'h1234);
        rd("R9 busy", 12'h000, 16'h0000);
        wr(12'h000, 16'h00FF);
        rd("R9 write ignored", 12'h000, 16'h0000);
        finish_op(1'b0, 1'b0);
        rd("R9 ready", 12'h000, 16'h0080);
        // R5 block erase, R10 erase fail
        wr(12'h000, 16'h0020); wr(12'h3FE, 16'h00D0);
        chk_start("R5", 2, 3'd2, 14'h0008);
        finish_op(1'b1, 1'b0);
        rd("R10 erase fail", 12'h000, 16'h00A0);
        wr(12'h200, 16'h0040); wr(12'h200, 16'hBEEF);
        finish_op(1'b0, 1'b0);
        rd("R10 sticky", 12'h000, 16'h00A0);
        wr(12'h000, 16'h0050);
        rd("R11 clear", 12'h000, 16'h0080);
        wr(12'h204, 16'h0040); wr(12'h204, 16'h0001);
        finish_op(1'b1, 1'b0);
        rd("R10 program fail", 12'h000, 16'h0090);
        wr(12'h000, 16'h0050);
        // R6 erase all
        wr(12'h000, 16'h00A7); wr(12'h000, 16'h00D0);
        chk_start("R6", 5, 3'd3, 14'h1FFF);
        finish_op(1'b0, 1'b0);
        // R8 sequence errors
        wr(12'h000, 16'h0020); wr(12'h1FE, 16'h00C0);
        chk_start("R8 bad confirm", 5, 3'd3, 14'h1FFF);
        rd("R8 flags", 12'h000, 16'h00B0);
        wr(12'h000, 16'h0050);
        rd("R11 after error", 12'h000, 16'h0080);
        wr(12'h100, 16'h0040); wr(12'h102, 16'h7777);
        @(negedge clk); chk("R8 address mismatch no start", 16'(n_start), 16'd5);
        rd("R8 flags", 12'h000, 16'h00B0);
        wr(12'h000, 16'h0050);
        // R10/R9 same-cycle completion and clear write
        wr(12'h000, 16'h0020); wr(12'h5FE, 16'h00D0);
        chk_start("R5", 6, 3'd2, 14'h0020);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = 16'h0050;
        eng_done = 1'b1; eng_fail = 1'b1;
        @(negedge clk); bus_wr = 1'b0; eng_done = 1'b0; eng_fail = 1'b0;
        rd("R10 clear dropped while busy", 12'h000, 16'h00A0);
        wr(12'h000, 16'h0050);
        // R7 lock operations
        wr(12'h000, 16'h0077); wr(12'h5FE, 16'h00D0);
        chk_start("R7 lock program", 7, 3'd4, 14'h0020);
        finish_op(1'b1, 1'b0);
        rd("R7 lock program fail", 12'h000, 16'h0090);
        wr(12'h000, 16'h0050);
        wr(12'h000, 16'h0071); wr(12'h1FE, 16'h00D0);
        chk_start("R7 lock read", 8, 3'd5, 14'h0002);
        finish_op(1'b0, 1'b1);
        rd("R7 lock bit", 12'h000, 16'h00C0);
        // R1 reset restores defaults
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd("R1 array after reset", 12'h010, 16'hA010);
        wr(12'h000, 16'h0070);
        rd("R1 status after reset", 12'h000, 16'h0080);
        summary();
    end
endmodule